// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits in front of a two-slot issue stage. Each cycle it is handed two decoded instructions in program order. Each has a valid bit and a class code. It also receives a vector of busy flags, one per execution unit. From these it decides whether nothing issues, the older instruction issues alone, or both issue as a pair. It names the execution unit that each issued instruction claims. The decision is formed combinationally and registered, so the outputs for one set of inputs appear after the next rising clock edge.

The pairing rules are asymmetric:
- Only integer arithmetic, register-file transfers, loads and stores may lead a pair.
- The younger slot accepts arithmetic, integer multiply/divide, HI/LO moves, branches and floating-point work.
- There are two integer add paths. One is on the memory pipe, which also generates addresses. The other is on the second pipe.
- All second-pipe units are mutually exclusive within a cycle.
- A branch ends the bundle.
- Unknown or multi-operation classes always go alone.

Register dependencies, forwarding and the units themselves are outside this block.

Top module: `dual_issue_pair_chk`

## Requirements
- R1: All outputs are registered. During reset they are 0, with both unit outputs 0 (none). After reset, the outputs show the decision for the inputs present at the preceding rising edge.
- R2: Class codes are: 0 simple integer, 1 integer/FP register transfer, 2 load, 3 store, 4 integer multiply, 5 integer divide, 6 HI/LO move, 7 branch/jump/call, 8 FP add/compare/convert, 9 FP multiply, 10 FP divide/sqrt, 11..15 unknown/multi. An older instruction of class 0 or 1 takes unit 1 (memory-pipe ALU) when busy bit 1 is clear. Otherwise it takes unit 2 (second-pipe ALU) when busy bit 2 is clear. Otherwise nothing issues.
- R3: An older load or store (class 2 or 3) issues only on unit 1, and stalls when busy bit 1 is set.
- R4: The other classes use dedicated units: classes 4, 5 and 6 use unit 4 (multiply/divide), class 7 uses unit 3 (branch), class 8 uses unit 5, class 9 uses unit 6 and class 10 uses unit 7. Such an instruction stalls when the busy bit of its unit is set. Busy bit k belongs to unit k, and busy bit 0 has no effect.
- R5: An older instruction of class 11..15 always issues alone, with unit 0, whatever the busy vector holds.
- R6: The younger instruction issues only in a cycle where the older one also issues. When the older one stalls, nothing issues.
- R7: A pair forms only when the older class is 0..3 and the younger class is 0, 1 or 4..10. A younger load, store or unknown never issues.
- R8: In a pair the older instruction must hold unit 1. A younger class 0 or 1 is steered to unit 2. If the older took unit 2, the younger does not issue.
- R9: An older branch (class 7) always issues alone.
- R10: When the unit needed by the younger instruction is busy, only the older instruction issues.
- R11: A slot whose valid bit is low never issues. A slot that does not issue reports unit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot0_vld_i | input | 1 | Older instruction present |
| slot0_cls_i | input | 4 | Older instruction class code |
| slot1_vld_i | input | 1 | Younger instruction present |
| slot1_cls_i | input | 4 | Younger instruction class code |
| unit_busy_i | input | 8 | Busy flag per unit code |
| slot0_go_o | output | 1 | Older instruction issues |
| slot1_go_o | output | 1 | Younger instruction issues |
| slot0_unit_o | output | 3 | Unit claimed by the older instruction |
| slot1_unit_o | output | 3 | Unit claimed by the younger instruction |

## Verification
Every decision is formed afresh from the current inputs and held in a single register stage. A wrong steering choice or exclusion decision therefore shows up at the ports exactly one cycle after the stimulus. Examples are a younger arithmetic instruction reported on unit 1, or a pair formed after the older instruction fell back to unit 2. No earlier state is involved. The directed scenarios pin down each class-to-unit mapping, the fallback between the two adders, and the cases where pairing must be refused: a busy unit, a branch, an unknown class, a younger load, or an older multiply. Each of these is compared one edge after it is applied.

// File: rtl/pair_pkg.sv
package pair_pkg;
    parameter int CLS_W     = 4;
    parameter int NUM_UNITS = 8;
    localparam int UNIT_W   = $clog2(NUM_UNITS);

    typedef logic [CLS_W-1:0]  cls_t;
    typedef logic [UNIT_W-1:0] unit_t;

    localparam cls_t C_SIMPLE = 4'd0;
    localparam cls_t C_XFER   = 4'd1;
    localparam cls_t C_LOAD   = 4'd2;
    localparam cls_t C_STORE  = 4'd3;
    localparam cls_t C_IMUL   = 4'd4;
    localparam cls_t C_IDIV   = 4'd5;
    localparam cls_t C_HILO   = 4'd6;
    localparam cls_t C_BRANCH = 4'd7;
    localparam cls_t C_FADD   = 4'd8;
    localparam cls_t C_FMUL   = 4'd9;
    localparam cls_t C_FDIV   = 4'd10;
    localparam cls_t C_FIRST_UNKNOWN = 4'd11;

    localparam unit_t U_NONE = 3'd0;
    localparam unit_t U_MEM  = 3'd1;
    localparam unit_t U_SEC  = 3'd2;
    localparam unit_t U_BR   = 3'd3;
    localparam unit_t U_MD   = 3'd4;
    localparam unit_t U_FADD = 3'd5;
    localparam unit_t U_FMUL = 3'd6;
    localparam unit_t U_FDIV = 3'd7;

    typedef struct packed {
        logic  go0;
        logic  go1;
        unit_t unit0;
        unit_t unit1;
    } issue_s;

    function automatic logic is_unknown(cls_t c);
        return c >= C_FIRST_UNKNOWN;
    endfunction

    function automatic logic is_alu(cls_t c);
        return (c == C_SIMPLE) || (c == C_XFER);
    endfunction

    function automatic logic is_mem(cls_t c);
        return (c == C_LOAD) || (c == C_STORE);
    endfunction

    // Dedicated unit for classes bound to exactly one unit; none otherwise.
    function automatic unit_t home_unit(cls_t c);
        unit_t u;
        case (c)
            C_IMUL, C_IDIV, C_HILO: u = U_MD;
            C_BRANCH:               u = U_BR;
            C_FADD:                 u = U_FADD;
            C_FMUL:                 u = U_FMUL;
            C_FDIV:                 u = U_FDIV;
            default:                u = U_NONE;
        endcase
        return u;
    endfunction
endpackage

// File: rtl/older_pick.sv
module older_pick
    import pair_pkg::*;
(
    input  logic                 vld_i,
    input  cls_t                 cls_i,
    input  logic [NUM_UNITS-1:0] busy_i,
    output logic                 ok_o,
    output unit_t                unit_o,
    output logic                 lead_o
);
    unit_t hu;

    always_comb begin
        hu     = home_unit(cls_i);
        ok_o   = 1'b0;
        unit_o = U_NONE;
        lead_o = 1'b0;
        if (vld_i) begin
            if (is_alu(cls_i)) begin
                if (!busy_i[U_MEM]) begin
                    ok_o   = 1'b1;
                    unit_o = U_MEM;
                end else if (!busy_i[U_SEC]) begin
                    ok_o   = 1'b1;
                    unit_o = U_SEC;
                end
                lead_o = ok_o;
            end else if (is_mem(cls_i)) begin
                if (!busy_i[U_MEM]) begin
                    ok_o   = 1'b1;
                    unit_o = U_MEM;
                end
                lead_o = ok_o;
            end else if (is_unknown(cls_i)) begin
                ok_o   = 1'b1;
                unit_o = U_NONE;
            end else if (!busy_i[hu]) begin
                ok_o   = 1'b1;
                unit_o = hu;
            end
        end
    end
endmodule

// File: rtl/younger_pick.sv
module younger_pick
    import pair_pkg::*;
(
    input  logic                 vld_i,
    input  cls_t                 cls_i,
    input  logic [NUM_UNITS-1:0] busy_i,
    input  logic                 old_ok_i,
    input  logic                 old_lead_i,
    input  unit_t                old_unit_i,
    output logic                 ok_o,
    output unit_t                unit_o
);
    unit_t cand;

    always_comb begin
        cand   = is_alu(cls_i) ? U_SEC : home_unit(cls_i);
        ok_o   = vld_i && old_ok_i && old_lead_i && (old_unit_i == U_MEM)
                 && (cand != U_NONE) && !busy_i[cand];
        unit_o = ok_o ? cand : U_NONE;
    end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot0_vld_i,
    input  logic [CLS_W-1:0]     slot0_cls_i,
    input  logic                 slot1_vld_i,
    input  logic [CLS_W-1:0]     slot1_cls_i,
    input  logic [NUM_UNITS-1:0] unit_busy_i,
    output logic                 slot0_go_o,
    output logic                 slot1_go_o,
    output logic [UNIT_W-1:0]    slot0_unit_o,
    output logic [UNIT_W-1:0]    slot1_unit_o
);
    logic   old_ok, old_lead, yng_ok;
    unit_t  old_unit, yng_unit;
    issue_s iss_d, iss_q;

    older_pick u_old (
        .vld_i  (slot0_vld_i),
        .cls_i  (slot0_cls_i),
        .busy_i (unit_busy_i),
        .ok_o   (old_ok),
        .unit_o (old_unit),
        .lead_o (old_lead)
    );

    younger_pick u_yng (
        .vld_i      (slot1_vld_i),
        .cls_i      (slot1_cls_i),
        .busy_i     (unit_busy_i),
        .old_ok_i   (old_ok),
        .old_lead_i (old_lead),
        .old_unit_i (old_unit),
        .ok_o       (yng_ok),
        .unit_o     (yng_unit)
    );

    always_comb begin
        iss_d       = '0;
        iss_d.go0   = old_ok;
        iss_d.unit0 = old_ok ? old_unit : U_NONE;
        iss_d.go1   = yng_ok;
        iss_d.unit1 = yng_unit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign slot0_go_o   = iss_q.go0;
    assign slot1_go_o   = iss_q.go1;
    assign slot0_unit_o = iss_q.unit0;
    assign slot1_unit_o = iss_q.unit1;
endmodule

// File: rtl/pair_chk_sva.sv
module pair_chk_sva
    import pair_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 slot0_vld_i,
    input logic [CLS_W-1:0]     slot0_cls_i,
    input logic                 slot1_vld_i,
    input logic [CLS_W-1:0]     slot1_cls_i,
    input logic [NUM_UNITS-1:0] unit_busy_i,
    input logic                 slot0_go_o,
    input logic                 slot1_go_o,
    input logic [UNIT_W-1:0]    slot0_unit_o,
    input logic [UNIT_W-1:0]    slot1_unit_o
);
    p_mem_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_vld_i && is_mem(slot0_cls_i) && unit_busy_i[U_MEM]) |=> !slot0_go_o);

    p_unknown_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_vld_i && is_unknown(slot0_cls_i)) |=>
            (slot0_go_o && !slot1_go_o && slot0_unit_o == U_NONE));

    p_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_go_o |-> slot0_go_o);

    p_young_mem_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_vld_i && (is_mem(slot1_cls_i) || is_unknown(slot1_cls_i))) |=> !slot1_go_o);

    p_second_pipe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_go_o |-> (slot0_unit_o == U_MEM && slot1_unit_o != U_MEM
                        && slot1_unit_o != U_NONE));

    p_branch_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_go_o && slot0_unit_o == U_BR) |-> !slot1_go_o);

    p_idle_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot0_go_o |-> slot0_unit_o == U_NONE) and (!slot1_go_o |-> slot1_unit_o == U_NONE));

    p_invalid_no_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_vld_i |=> !slot0_go_o);
endmodule

bind dual_issue_pair_chk pair_chk_sva u_sva (.*);

// File: tb/tb_dual_issue_pair_chk.sv
module tb_dual_issue_pair_chk;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       v0, v1;
    logic [3:0] c0, c1;
    logic [7:0] busy;
    logic       go0, go1;
    logic [2:0] u0, u1;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_issue_pair_chk dut (
        .clk(clk), .rst_n(rst_n),
        .slot0_vld_i(v0), .slot0_cls_i(c0),
        .slot1_vld_i(v1), .slot1_cls_i(c1),
        .unit_busy_i(busy),
        .slot0_go_o(go0), .slot1_go_o(go1),
        .slot0_unit_o(u0), .slot1_unit_o(u1)
    );

    task automatic check(string req, logic g0, logic g1, logic [2:0] e0, logic [2:0] e1);
        total++;
        if (go0 !== g0 || go1 !== g1 || u0 !== e0 || u1 !== e1) begin
            bad++;
            $display("FAIL %s: got go=%b%b units=%0d,%0d expected go=%b%b units=%0d,%0d",
                     req, go0, go1, u0, u1, g0, g1, e0, e1);
        end
    endtask

    // Apply inputs, let one rising edge register them, compare just after.
    task automatic step(string req, logic a0, logic [3:0] k0, logic a1, logic [3:0] k1,
                        logic [7:0] b, logic g0, logic g1, logic [2:0] e0, logic [2:0] e1);
        v0 = a0; c0 = k0; v1 = a1; c1 = k1; busy = b;
        @(posedge clk); #1;
        check(req, g0, g1, e0, e1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; v0 = 1'b1; c0 = 4'd0; v1 = 1'b1; c1 = 4'd0; busy = '0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        v0 = 1'b0; v1 = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_latency();
        step("R1 idle", 0, 0, 0, 0, 8'h00, 0, 0, 0, 0);
        v0 = 1'b1; c0 = 4'd0; busy = 8'h00;
        #1 check("R1 not before edge", 0, 0, 0, 0);
        @(posedge clk); #1;
        check("R1 after edge", 1, 0, 1, 0);
    endtask

    task automatic t_older_alu();
        step("R2 simple free",      1, 4'd0, 0, 0, 8'h00, 1, 0, 1, 0);
        step("R2 simple mem busy",  1, 4'd0, 0, 0, 8'h02, 1, 0, 2, 0);
        step("R2 xfer mem busy",    1, 4'd1, 0, 0, 8'h02, 1, 0, 2, 0);
        step("R2 both adders busy", 1, 4'd0, 0, 0, 8'h06, 0, 0, 0, 0);
    endtask

    task automatic t_mem();
        step("R3 load sec busy", 1, 4'd2, 0, 0, 8'h04, 1, 0, 1, 0);
        step("R3 store",         1, 4'd3, 0, 0, 8'h00, 1, 0, 1, 0);
        step("R3 load mem busy", 1, 4'd2, 0, 0, 8'h02, 0, 0, 0, 0);
    endtask

    task automatic t_dedicated();
        step("R4 imul",  1, 4'd4,  0, 0, 8'h00, 1, 0, 4, 0);
        step("R4 idiv",  1, 4'd5,  0, 0, 8'h00, 1, 0, 4, 0);
        step("R4 hilo",  1, 4'd6,  0, 0, 8'h00, 1, 0, 4, 0);
        step("R4 branch",1, 4'd7,  0, 0, 8'h00, 1, 0, 3, 0);
        step("R4 fadd",  1, 4'd8,  0, 0, 8'h00, 1, 0, 5, 0);
        step("R4 fmul",  1, 4'd9,  0, 0, 8'h00, 1, 0, 6, 0);
        step("R4 fdiv",  1, 4'd10, 0, 0, 8'h00, 1, 0, 7, 0);
        step("R4 fmul busy", 1, 4'd9, 0, 0, 8'h40, 0, 0, 0, 0);
        step("R4 bit0 no effect", 1, 4'd4, 0, 0, 8'h01, 1, 0, 4, 0);
    endtask

    task automatic t_unknown();
        step("R5 unknown all busy", 1, 4'd11, 1, 4'd0, 8'hFF, 1, 0, 0, 0);
        step("R5 multi pair try",   1, 4'd15, 1, 4'd8, 8'h00, 1, 0, 0, 0);
    endtask

    task automatic t_order();
        step("R6 older stalls", 1, 4'd2, 1, 4'd8, 8'h02, 0, 0, 0, 0);
        step("R11 older invalid", 0, 4'd0, 1, 4'd0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic t_pairs();
        step("R8 alu pair",       1, 4'd0, 1, 4'd0,  8'h00, 1, 1, 1, 2);
        step("R7 load+fmul",      1, 4'd2, 1, 4'd9,  8'h00, 1, 1, 1, 6);
        step("R7 store+branch",   1, 4'd3, 1, 4'd7,  8'h00, 1, 1, 1, 3);
        step("R7 xfer+hilo",      1, 4'd1, 1, 4'd6,  8'h00, 1, 1, 1, 4);
        step("R7 young load",     1, 4'd0, 1, 4'd2,  8'h00, 1, 0, 1, 0);
        step("R7 young unknown",  1, 4'd0, 1, 4'd12, 8'h00, 1, 0, 1, 0);
        step("R7 older imul",     1, 4'd4, 1, 4'd0,  8'h00, 1, 0, 4, 0);
        step("R8 older on sec",   1, 4'd0, 1, 4'd8,  8'h02, 1, 0, 2, 0);
        step("R8 sec busy young", 1, 4'd0, 1, 4'd1,  8'h04, 1, 0, 1, 0);
    endtask

    task automatic t_branch_young_busy();
        step("R9 branch leads",   1, 4'd7, 1, 4'd0,  8'h00, 1, 0, 3, 0);
        step("R10 muldiv busy",   1, 4'd0, 1, 4'd5,  8'h10, 1, 0, 1, 0);
        step("R10 fdiv busy",     1, 4'd3, 1, 4'd10, 8'h80, 1, 0, 1, 0);
        step("R11 young invalid", 1, 4'd0, 0, 4'd8,  8'h00, 1, 0, 1, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_older_alu();
        t_mem();
        t_dedicated();
        t_unknown();
        t_order();
        t_pairs();
        t_branch_young_busy();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule